// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets a host processor reach a slow register subsystem that is addressed one byte at a time. The host sees a small window of 32-bit registers: an identity word, a command word, two data words, an interrupt enable word and an interrupt flag word. The command word carries the subsystem byte address, the direction, a size bit and two groups of byte enables. Transfers are not started by a dedicated "go" bit. Writing the lower data word starts a write to the subsystem when the direction bit is clear. Writing the command word with the direction bit set starts a read.

While a transfer is in flight, a busy bit in the command word reads as one, and software polls it. The subsystem side is a byte-wide request/acknowledge port. The request stays high, with steady address, direction and data, until the subsystem acknowledges. A completed read leaves the fetched byte in the low byte of the lower data word.

The interrupt flag register combines an interrupt input from the subsystem with the bridge's own completion event. The interrupt enable register selects which flags drive the single interrupt output.

Top module: `regwin_bridge`

## Requirements
- R1: After reset, every writable register reads zero, busy is clear, `sub_req` and `irq` are low, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: A write to offset 0x04 while idle stores the fields of the command word. These are byte address [7:0], lower byte enables [19:16], upper byte enables [23:20], direction [24] (1 = read) and size [25]. Reading offset 0x04 returns them with bit 31 equal to busy. Bit 31 and the other bits cannot be written.
- R3: A write to the lower data word (0x08) while idle with direction 0 stores the word. In the next cycle `sub_req` is high with `sub_we`=1 and `sub_addr` equal to the stored byte address.
- R4: A write to 0x04 while idle with bit 24 set raises `sub_req` in the next cycle with `sub_we`=0 and `sub_addr` equal to the new address.
- R5: Busy and `sub_req` fall at the clock edge where `sub_ack` is sampled high. For a read, the lower data word then reads `{24'h0, sub_rdata}` as sampled at that edge.
- R6: While busy, writes to 0x04, 0x08 and 0x0C are ignored. They change no readback value and start no transfer, and the request outputs keep their values until acknowledge.
- R7: Flag bit 0 (offset 0x14) sets when a transfer completes. Flag bit 1 sets on any cycle with `sub_irq` high. Writing 1 to a flag bit clears it. A set in the same cycle as the clear wins.
- R8: `irq` is high exactly when some flag bit and its enable bit at offset 0x10 (bits 1:0) are both set.
- R9: A `sub_ack` arriving while idle has no effect on busy, flags or the data words.
- R10: The byte sent on `sub_wdata` is the lane of the lower data word picked by the lowest set lower byte enable. Enable bit 16 picks [7:0], bit 17 picks [15:8], bit 18 picks [23:16] and bit 19 picks [31:24]. With no lower enable set, lane [7:0] is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 5 | Host byte offset of the window register (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| sub_req | output | 1 | Subsystem transfer request, high while busy |
| sub_we | output | 1 | 1 = write transfer, 0 = read transfer |
| sub_addr | output | 8 | Subsystem byte address |
| sub_wdata | output | 8 | Byte written to the subsystem |
| sub_rdata | input | 8 | Byte returned by the subsystem with acknowledge |
| sub_ack | input | 1 | Subsystem acknowledge, ends the transfer |
| sub_irq | input | 1 | Interrupt from the subsystem |
| irq | output | 1 | Combined interrupt output |

## Verification
Suppose the busy state is corrupted. A missed launch or a missed clear shows on `sub_req` and command bit 31 one cycle after the offending write or acknowledge. That is enough to tell a dropped launch from a request that never ends. A wrong stored address or byte-enable choice shows up only while the request is high, as a wrong `sub_addr` or `sub_wdata`. So every launch is checked in the cycle right after its write. A wrong capture of read data or a flag error stays hidden until the host reads offset 0x08 or 0x14 or watches `irq`. The bench reads those back right after each acknowledge and after each clear.

// File: rtl/regwin_bridge.sv
module regwin_bridge #(
  parameter logic [31:0] ID_VALUE = 32'h5EB1_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        sub_req,
  output logic        sub_we,
  output logic [7:0]  sub_addr,
  output logic [7:0]  sub_wdata,
  input  logic [7:0]  sub_rdata,
  input  logic        sub_ack,
  input  logic        sub_irq,
  output logic        irq
);
  localparam logic [4:0] OFS_ID = 5'h00, OFS_CMD = 5'h04, OFS_LO = 5'h08,
                         OFS_HI = 5'h0C, OFS_EN = 5'h10, OFS_FLG = 5'h14;

  logic        busy_q, dir_q, size_q;
  logic [7:0]  addr_q;
  logic [3:0]  lbe_q, ube_q;
  logic [31:0] lo_q, hi_q;
  logic [1:0]  en_q, flg_q;

  wire wr_cmd = host_wr && host_addr == OFS_CMD;
  wire wr_lo  = host_wr && host_addr == OFS_LO;
  wire wr_hi  = host_wr && host_addr == OFS_HI;
  wire wr_en  = host_wr && host_addr == OFS_EN;
  wire wr_flg = host_wr && host_addr == OFS_FLG;
  wire done   = busy_q && sub_ack;
  wire launch = !busy_q && ((wr_cmd && host_wdata[24]) || (wr_lo && !dir_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; dir_q <= 1'b0; size_q <= 1'b0; addr_q <= '0;
      lbe_q <= '0; ube_q <= '0; lo_q <= '0; hi_q <= '0; en_q <= '0; flg_q <= '0;
    end else begin
      if (wr_cmd && !busy_q) begin
        addr_q <= host_wdata[7:0];
        lbe_q  <= host_wdata[19:16];
        ube_q  <= host_wdata[23:20];
        dir_q  <= host_wdata[24];
        size_q <= host_wdata[25];
      end
      if (wr_lo && !busy_q) lo_q <= host_wdata;
      else if (done && dir_q) lo_q <= {24'h0, sub_rdata};
      if (wr_hi && !busy_q) hi_q <= host_wdata;
      if (wr_en) en_q <= host_wdata[1:0];
      flg_q <= (flg_q & ~(wr_flg ? host_wdata[1:0] : 2'b00)) | {sub_irq, done};
      if (launch) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
    end
  end

  always_comb begin
    casez (lbe_q)
      4'b???1: sub_wdata = lo_q[7:0];
      4'b??10: sub_wdata = lo_q[15:8];
      4'b?100: sub_wdata = lo_q[23:16];
      4'b1000: sub_wdata = lo_q[31:24];
      default: sub_wdata = lo_q[7:0];
    endcase
  end

  always_comb begin
    case (host_addr)
      OFS_ID:  host_rdata = ID_VALUE;
      OFS_CMD: host_rdata = {busy_q, 5'h0, size_q, dir_q, ube_q, lbe_q, 8'h0, addr_q};
      OFS_LO:  host_rdata = lo_q;
      OFS_HI:  host_rdata = hi_q;
      OFS_EN:  host_rdata = {30'h0, en_q};
      OFS_FLG: host_rdata = {30'h0, flg_q};
      default: host_rdata = 32'h0;
    endcase
  end

  assign sub_req  = busy_q;
  assign sub_we   = !dir_q;
  assign sub_addr = addr_q;
  assign irq      = |(flg_q & en_q);
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [4:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        sub_req,
  input logic        sub_we,
  input logic [7:0]  sub_addr,
  input logic [7:0]  sub_wdata,
  input logic        sub_ack,
  input logic        dir,
  input logic [1:0]  flg
);
  p_write_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 5'h08 && !sub_req && !dir) |=> (sub_req && sub_we));

  p_read_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 5'h04 && host_wdata[24] && !sub_req)
      |=> (sub_req && !sub_we && sub_addr == $past(host_wdata[7:0])));

  p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_req && sub_ack) |=> !sub_req);

  p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_req && !sub_ack)
      |=> (sub_req && $stable(sub_addr) && $stable(sub_we) && $stable(sub_wdata)));

  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_req && sub_ack) |=> flg[0]);

  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_req && sub_ack && !(host_wr && (host_addr == 5'h04 || host_addr == 5'h08)))
      |=> !sub_req);
endmodule

bind regwin_bridge regwin_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .sub_req(sub_req), .sub_we(sub_we),
  .sub_addr(sub_addr), .sub_wdata(sub_wdata), .sub_ack(sub_ack),
  .dir(dir_q), .flg(flg_q)
);

// File: tb/test_regwin_bridge.sv
module test_regwin_bridge;
  localparam logic [31:0] ID = 32'h5EB1_0001;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic sub_req, sub_we, sub_ack = 1'b0, sub_irq = 1'b0, irq;
  logic [7:0] sub_addr, sub_wdata, sub_rdata = '0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  regwin_bridge #(.ID_VALUE(ID)) i_regwin_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sub_req(sub_req),
    .sub_we(sub_we), .sub_addr(sub_addr), .sub_wdata(sub_wdata),
    .sub_rdata(sub_rdata), .sub_ack(sub_ack), .sub_irq(sub_irq), .irq(irq));

  function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [3:0] be);
    if (be[0]) return w[7:0];
    if (be[1]) return w[15:8];
    if (be[2]) return w[23:16];
    if (be[3]) return w[31:24];
    return w[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic ack(input logic [7:0] v);
    @(negedge clk); sub_ack = 1'b1; sub_rdata = v;
    @(negedge clk); sub_ack = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] r, cmd, dat;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, r); check("R1 id", r, ID);
    rd(5'h04, r); check("R1 cmd", r, 0);
    rd(5'h08, r); check("R1 lo", r, 0);
    rd(5'h14, r); check("R1 flg", r, 0);
    check("R1 req", sub_req, 0);
    check("R1 irq", irq, 0);
    // R2 command fields, bit31 read-only
    wr(5'h04, 32'h8ED1_0025);
    rd(5'h04, r); check("R2 cmd readback", r, 32'h02D1_0025);
    check("R2 no launch", sub_req, 0);
    wr(5'h04, 32'h0001_0025);
    // R3 write launch
    wr(5'h08, 32'h0000_00A7);
    check("R3 req", sub_req, 1);
    check("R3 we", sub_we, 1);
    check("R3 addr", sub_addr, 8'h25);
    check("R10 lane0", sub_wdata, 8'hA7);
    rd(5'h04, r); check("R2 busy bit", r[31], 1);
    // R6 writes while busy ignored
    wr(5'h04, 32'h0100_0011);
    wr(5'h08, 32'h1234_5678);
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h04, r); check("R6 cmd kept", r, 32'h8001_0025);
    rd(5'h08, r); check("R6 lo kept", r, 32'h0000_00A7);
    rd(5'h0C, r); check("R6 hi kept", r, 0);
    check("R6 addr kept", sub_addr, 8'h25);
    check("R6 still req", sub_req, 1);
    // R5 completion
    ack(8'h00);
    check("R5 req low", sub_req, 0);
    rd(5'h14, r); check("R7 done flag", r, 1);
    // R8 irq gating
    check("R8 masked", irq, 0);
    wr(5'h10, 32'h1);
    check("R8 enabled", irq, 1);
    wr(5'h14, 32'h1);
    rd(5'h14, r); check("R7 w1c", r, 0);
    check("R8 cleared", irq, 0);
    // R4 read launch, R5 capture
    wr(5'h04, 32'h0101_0040);
    check("R4 req", sub_req, 1);
    check("R4 we", sub_we, 0);
    check("R4 addr", sub_addr, 8'h40);
    ack(8'h5C);
    rd(5'h08, r); check("R5 read data", r, 32'h0000_005C);
    check("R5 req low", sub_req, 0);
    wr(5'h14, 32'h3);
    // R10 lane select, data write with dir=0 only
    wr(5'h04, 32'h0004_0007);
    wr(5'h08, 32'h1122_3344);
    check("R10 lane2", sub_wdata, 8'h22);
    check("R10 addr", sub_addr, 8'h07);
    ack(8'hFF);
    rd(5'h08, r); check("R5 write keeps lo", r, 32'h1122_3344);
    wr(5'h14, 32'h3);
    // R9 idle ack
    ack(8'hEE);
    check("R9 req", sub_req, 0);
    rd(5'h14, r); check("R9 flg", r, 0);
    rd(5'h08, r); check("R9 lo", r, 32'h1122_3344);
    // R7 sub_irq flag, set wins over clear
    @(negedge clk); sub_irq = 1'b1;
    @(negedge clk); sub_irq = 1'b0;
    rd(5'h14, r); check("R7 sub flag", r, 2);
    check("R8 sub masked", irq, 0);
    wr(5'h10, 32'h2);
    check("R8 sub irq", irq, 1);
    @(negedge clk); sub_irq = 1'b1; host_wr = 1'b1; host_addr = 5'h14; host_wdata = 32'h2;
    @(negedge clk); sub_irq = 1'b0; host_wr = 1'b0;
    rd(5'h14, r); check("R7 set wins", r, 2);
    wr(5'h14, 32'h2);
    rd(5'h14, r); check("R7 cleared", r, 0);
    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      logic [3:0] be;
      a = 8'($urandom); be = 4'($urandom); dat = $urandom; b = 8'($urandom);
      if ($urandom % 2) begin
        cmd = {12'h0, be, 8'h0, a};
        wr(5'h04, cmd);
        wr(5'h08, dat);
        check("R3 rnd req", {sub_req, sub_we}, 2'b11);
        check("R3 rnd addr", sub_addr, a);
        check("R10 rnd lane", sub_wdata, lane_of(dat, be));
        repeat ($urandom % 4) @(negedge clk);
        ack(b);
        rd(5'h08, r); check("R5 rnd lo", r, dat);
      end else begin
        wr(5'h04, {7'h0, 1'b1, 4'h0, be, 8'h0, a});
        check("R4 rnd req", {sub_req, sub_we}, 2'b10);
        check("R4 rnd addr", sub_addr, a);
        repeat ($urandom % 4) @(negedge clk);
        ack(b);
        rd(5'h08, r); check("R5 rnd rdata", r, {24'h0, b});
      end
      check("R5 rnd idle", sub_req, 0);
      rd(5'h14, r); check("R7 rnd flag", r[0], 1);
      wr(5'h14, 32'h1);
    end
    finished = 1;
    summary();
  end
endmodule